// File: doc/BRIEF.md
# Buffered Serial Channel with Programmable Thresholds

This block is an asynchronous serial port: one start bit, eight data bits sent least significant bit first, one stop bit. It has a 16-entry queue for outgoing bytes and a 16-entry queue for incoming bytes. Software reaches it through a 16-bit register window. The window holds a channel control register, a transmit data port and a receive data port, a status register whose flags are cleared by writing zero, a FIFO control register, a fill-count register, and a line register that records overrun.

Three flags come from comparing the queue fill levels against thresholds that software selects through small encoded fields: receive-full, data-ready and transmit-queue-empty. The same receive level, checked against a separate threshold table, drives an active-low request-to-send output so that a remote sender can be paused. A loopback mode sends the transmit serial stream straight into the receiver. The line period is `CLKS_PER_BIT` clocks. A register read returns its data on the clock after the read strobe.

Top module: `fifo_serial_chan`

## Requirements
- R1: After reset, status (address 3) reads 0x0060 (transmit end bit 6 and transmit-queue-empty bit 5 set), fill count (address 5) reads 0, line register (address 6) reads 0, txd is 1 and rts_n is 0.
- R2: Bytes written to address 1 leave on txd in write order, 8N1, least significant bit first, `CLKS_PER_BIT` clocks per bit. They leave only while channel control (address 0) bit 5 (transmit enable) is 1. Otherwise txd stays 1.
- R3: A frame received on rxd while address 0 bit 4 (receive enable) is 1 enters the receive queue. Reading address 2 pops bytes in arrival order. Address 5 shows the receive count in bits 4:0 and the transmit count in bits 12:8.
- R4: A byte that arrives while the receive queue holds 16 bytes is dropped and sets line register bit 0. A read of address 6 returns that bit and clears it.
- R5: Receive-full (status bit 1) becomes set when the receive count is at or above the threshold chosen by FIFO control (address 4) bits 7:6. The codes 0, 1, 2 and 3 select 1, 4, 8 and 14.
- R6: Data-ready (status bit 0) becomes set when the receive count is nonzero and below the receive threshold. It is held at 0 while receive-full is set, so the two are never 1 together.
- R7: Transmit-queue-empty (status bit 5) becomes set while the transmit count is at or below the threshold chosen by address 4 bits 5:4. The codes 0, 1, 2 and 3 select 8, 4, 2 and 1. Writing 0 to the bit clears it only while the count is above the threshold.
- R8: A write to the status register clears each of bits 7:0 written as 0 and keeps each written as 1. A flag whose set condition holds in the same cycle stays set. Bits 15:8 read 0.
- R9: Transmit end (status bit 6) is set when the stop bit of the last queued byte finishes, and also on any write to address 0 with bit 5 at 0. It is cleared by a write to address 1 or by writing 0 to it.
- R10: With address 4 bit 3 at 1, rts_n is 1 while the receive count is at or above the level chosen by bits 10:8. The codes 0 through 7 select 15, 1, 4, 6, 8, 10, 12 and 14. With bit 3 at 0, rts_n is 0.
- R11: While address 4 bit 2 is 1 the transmit queue is held empty, and while bit 1 is 1 the receive queue is held empty.
- R12: With address 4 bit 0 at 1, the transmit serial stream feeds the receiver internally, rxd is ignored and txd is held at 1.
- R13: A received frame whose stop bit is 0 is still stored, and it sets status bit 3 (framing error) and bit 7 (receive error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Active-low request to send |

## Verification
The receive path is driven with short bursts that leave the count below the threshold, bursts that reach it exactly, and a burst of seventeen bytes. Together these separate data-ready from receive-full, show the exact threshold boundary, and show the drop on overflow. The transmit path runs with transmission enabled, then with it disabled and ten bytes queued, then in loopback. This distinguishes real transmission from stalled data from internal wrap-around, and a serial monitor in the bench rebuilds every byte seen on txd. Status writes use all-ones and single-zero patterns to separate write-zero-to-clear from write-one-to-keep, and the flow-control output is checked on both sides of its threshold with modem control enabled and disabled.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TXD  = 3'd1;
  localparam logic [2:0] A_RXD  = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_FCTL = 3'd4;
  localparam logic [2:0] A_CNT  = 3'd5;
  localparam logic [2:0] A_LINE = 3'd6;

  // receive-full threshold: 1, 4, 8, 14
  function automatic logic [4:0] rx_trig_f(input logic [1:0] c);
    case (c)
      2'd0: rx_trig_f = 5'd1;
      2'd1: rx_trig_f = 5'd4;
      2'd2: rx_trig_f = 5'd8;
      default: rx_trig_f = 5'd14;
    endcase
  endfunction

  // transmit-empty threshold: 8, 4, 2, 1
  function automatic logic [4:0] tx_trig_f(input logic [1:0] c);
    tx_trig_f = 5'd8 >> c;
  endfunction

  // flow-control level: 15 for code 0, 1 for code 1, else twice the code
  function automatic logic [4:0] rts_trig_f(input logic [2:0] c);
    if (c == 3'd0)      rts_trig_f = 5'd15;
    else if (c == 3'd1) rts_trig_f = 5'd1;
    else                rts_trig_f = {1'b0, c, 1'b0};
  endfunction
endpackage

// File: rtl/fsc_fifo.sv
module fsc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign dout    = mem[rp];

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= din;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> full);
  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/fsc_tx.sv
module fsc_tx #(
  parameter int CPB = 16,
  localparam int BCW = $clog2(CPB) + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] data,
  output logic       line,
  output logic       busy,
  output logic       done
);
  logic [8:0]     sh;
  logic [3:0]     bitn;
  logic [BCW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= 1'b1; busy <= 1'b0; done <= 1'b0;
      sh <= '1; bitn <= '0; bcnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (load) begin
          sh <= {1'b1, data}; line <= 1'b0; busy <= 1'b1;
          bitn <= '0; bcnt <= '0;
        end
      end else if (bcnt == BCW'(CPB-1)) begin
        bcnt <= '0;
        if (bitn == 4'd9) begin
          busy <= 1'b0; done <= 1'b1; line <= 1'b1;
        end else begin
          line <= sh[0];
          sh   <= {1'b1, sh[8:1]};
          bitn <= bitn + 1'b1;
        end
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsc_rx.sv
module fsc_rx
  import fsc_pkg::*;
#(
  parameter int CPB = 16,
  localparam int BCW  = $clog2(CPB) + 1,
  localparam int HALF = CPB / 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line,
  output logic       vld,
  output logic [7:0] data,
  output logic       ferr
);
  rx_state_t      st;
  logic           s1, s2, prev;
  logic [7:0]     sh;
  logic [2:0]     bitn;
  logic [BCW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_IDLE; s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
      sh <= '0; bitn <= '0; bcnt <= '0;
      vld <= 1'b0; data <= '0; ferr <= 1'b0;
    end else begin
      s1 <= line; s2 <= s1; prev <= s2;
      vld <= 1'b0;
      case (st)
        RX_IDLE:
          if (prev && !s2) begin st <= RX_START; bcnt <= '0; end
        RX_START:
          if (bcnt == BCW'(HALF-1)) begin
            bcnt <= '0; bitn <= '0;
            st <= s2 ? RX_IDLE : RX_DATA;
          end else bcnt <= bcnt + 1'b1;
        RX_DATA:
          if (bcnt == BCW'(CPB-1)) begin
            bcnt <= '0;
            sh   <= {s2, sh[7:1]};
            if (bitn == 3'd7) st <= RX_STOP;
            else bitn <= bitn + 1'b1;
          end else bcnt <= bcnt + 1'b1;
        default:
          if (bcnt == BCW'(CPB-1)) begin
            bcnt <= '0; vld <= 1'b1; data <= sh; ferr <= ~s2;
            st <= RX_IDLE;
          end else bcnt <= bcnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fifo_serial_chan.sv
module fifo_serial_chan
  import fsc_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int CLKS_PER_BIT = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        rts_n
);
  logic [15:0]   ctrl_q, fctl_q;
  logic [7:0]    stat_q, keep, stat_n;
  logic          ovr_q, ovr_set;
  logic          wr_ctrl, wr_txd, wr_stat, wr_fctl, rd_rxd, rd_line;
  logic          te, re, lb, mce;
  logic [CW-1:0] tx_cnt, rx_cnt, rx_trig, tx_trig, rts_trig;
  logic [7:0]    tx_dout, rx_dout, rx_byte;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_load, tx_line, tx_busy, tx_done;
  logic          rx_vld, rx_ferr, rx_in, rdf_n;

  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
  assign wr_txd  = reg_wr && reg_addr == A_TXD;
  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign wr_fctl = reg_wr && reg_addr == A_FCTL;
  assign rd_rxd  = reg_rd && reg_addr == A_RXD;
  assign rd_line = reg_rd && reg_addr == A_LINE;

  assign te  = ctrl_q[5];
  assign re  = ctrl_q[4];
  assign lb  = fctl_q[0];
  assign mce = fctl_q[3];
  assign rx_trig  = CW'(rx_trig_f(fctl_q[7:6]));
  assign tx_trig  = CW'(tx_trig_f(fctl_q[5:4]));
  assign rts_trig = CW'(rts_trig_f(fctl_q[10:8]));

  fsc_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(fctl_q[2]), .push(wr_txd & ~tx_full),
    .din(reg_wdata[7:0]), .pop(tx_load), .dout(tx_dout), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty));

  fsc_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(fctl_q[1]), .push(rx_vld & re),
    .din(rx_byte), .pop(rd_rxd), .dout(rx_dout), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty));

  assign tx_load = te & ~tx_busy & ~tx_empty & ~fctl_q[2];

  fsc_tx #(.CPB(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .data(tx_dout),
    .line(tx_line), .busy(tx_busy), .done(tx_done));

  assign rx_in = lb ? tx_line : rxd;

  fsc_rx #(.CPB(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst(rst), .line(rx_in), .vld(rx_vld), .data(rx_byte),
    .ferr(rx_ferr));

  assign ovr_set = rx_vld & re & rx_full & ~fctl_q[1];
  assign keep    = wr_stat ? reg_wdata[7:0] : 8'hFF;
  assign rdf_n   = (stat_q[1] & keep[1]) | (rx_cnt >= rx_trig);

  always_comb begin
    stat_n    = 8'h00;
    stat_n[7] = (stat_q[7] & keep[7]) | (rx_vld & re & rx_ferr);
    stat_n[6] = wr_txd ? 1'b0 :
                (stat_q[6] & keep[6]) | (wr_ctrl & ~reg_wdata[5]) |
                (tx_done & tx_empty);
    stat_n[5] = (stat_q[5] & keep[5]) | (tx_cnt <= tx_trig);
    stat_n[3] = (stat_q[3] & keep[3]) | (rx_vld & re & rx_ferr);
    stat_n[1] = rdf_n;
    stat_n[0] = ~rdf_n & ((stat_q[0] & keep[0]) |
                          (rx_cnt != '0 && rx_cnt < rx_trig));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; fctl_q <= '0; stat_q <= 8'h60; ovr_q <= 1'b0;
      rts_n <= 1'b0; txd <= 1'b1; reg_rdata <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (wr_fctl) fctl_q <= reg_wdata;
      stat_q <= stat_n;
      ovr_q  <= ovr_set | (ovr_q & ~rd_line);
      rts_n  <= mce & (rx_cnt >= rts_trig);
      txd    <= lb | tx_line;
      if (reg_rd) begin
        case (reg_addr)
          A_CTRL:  reg_rdata <= ctrl_q;
          A_RXD:   reg_rdata <= rx_empty ? 16'h0 : {8'h00, rx_dout};
          A_STAT:  reg_rdata <= {8'h00, stat_q};
          A_FCTL:  reg_rdata <= fctl_q;
          A_CNT:   reg_rdata <= {3'b000, 5'(tx_cnt), 3'b000, 5'(rx_cnt)};
          A_LINE:  reg_rdata <= {15'h0, ovr_q};
          default: reg_rdata <= 16'h0;
        endcase
      end
    end
  end

  // R4
  ovr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_set |=> ovr_q);
  // R5
  rdf_level_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt >= rx_trig) |=> stat_q[1]);
  // R6
  dr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt != '0 && rx_cnt < rx_trig) |=> (stat_q[0] ^ stat_q[1]));
  // R7
  tdfe_level_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt <= tx_trig) |=> stat_q[5]);
  // R9
  tend_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !reg_wdata[5]) |=> stat_q[6]);
  // R10
  rts_level_chk: assert property (@(posedge clk) disable iff (rst)
    (mce && rx_cnt >= rts_trig) |=> rts_n);
endmodule

// File: tb/test_fifo_serial_chan.sv
module test_fifo_serial_chan;
  localparam int CPB = 8;
  logic clk = 0, rst = 1;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0, rxd = 1;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic txd, rts_n;
  int total = 0, bad = 0;
  bit quiet = 0;
  byte unsigned rx_model[$], tx_exp[$], tx_got[$];

  always #10 clk = ~clk;

  fifo_serial_chan #(.DEPTH(16), .CLKS_PER_BIT(CPB)) i_fifo_serial_chan (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd(rxd), .txd(txd), .rts_n(rts_n));

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    rxd = 0; repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (CPB) @(negedge clk); end
    rxd = stop; repeat (CPB) @(negedge clk);
    rxd = 1; repeat (CPB) @(negedge clk);
  endtask

  // behavioural receive-side model: accept unless 16 already held
  task automatic send_m(input logic [7:0] b);
    send(b, 1'b1);
    if (rx_model.size() < 16) rx_model.push_back(b);
  endtask

  task automatic drain(input string r, input int n);
    logic [15:0] d;
    for (int i = 0; i < n; i++) begin
      rd(3'd2, d);
      chk(r, d, {8'h00, rx_model.pop_front()});
    end
  endtask

  // serial monitor on txd
  initial forever begin
    @(negedge clk);
    if (!rst && txd === 1'b0) begin
      logic [7:0] b;
      repeat (CPB/2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin repeat (CPB) @(negedge clk); b[i] = txd; end
      repeat (CPB) @(negedge clk);
      tx_got.push_back(b);
    end
  end

  // every-clock comparison: line must idle when the model expects silence
  always @(negedge clk) if (quiet) begin
    total++;
    if (txd !== 1'b1) begin bad++; $display("FAIL R2/R12 txd act=%b exp=1", txd); end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk); rst = 0; @(negedge clk);
    // R1 reset state
    rd(3'd3, d); chk("R1 status", d, 16'h0060);
    rd(3'd5, d); chk("R1 count", d, 16'h0000);
    rd(3'd6, d); chk("R1 line", d, 16'h0000);
    chk("R1 txd", txd, 1); chk("R1 rts_n", rts_n, 0);

    // R2 transmit, R9 end flag
    wr(3'd0, 16'h0030);
    foreach (tx_exp[i]) ;
    tx_exp = '{8'hA5, 8'h3C, 8'h01};
    foreach (tx_exp[i]) wr(3'd1, {8'h00, tx_exp[i]});
    repeat (3*10*CPB + 60) @(negedge clk);
    chk("R2 frames", tx_got.size(), 3);
    foreach (tx_exp[i]) if (i < tx_got.size()) chk("R2 byte", tx_got[i], tx_exp[i]);
    rd(3'd3, d); chk("R9 R7 status after send", d, 16'h0060);

    // R3 receive, R5 code0 (1), R6
    send_m(8'h11); send_m(8'h22); send_m(8'h33);
    rd(3'd5, d); chk("R3 count", d, 16'h0003);
    rd(3'd3, d); chk("R5 R6 rdf set dr clear", d, 16'h0062);
    drain("R3 order", 3);
    wr(3'd3, 16'hFFFD);
    rd(3'd3, d); chk("R8 clear rdf", d, 16'h0060);

    // R5 code2 (8), R6 below threshold
    wr(3'd4, 16'h0080);
    send_m(8'h41); send_m(8'h42); send_m(8'h43);
    rd(3'd3, d); chk("R6 dr below trig", d, 16'h0061);
    send_m(8'h44); send_m(8'h45); send_m(8'h46); send_m(8'h47);
    rd(3'd3, d); chk("R5 count 7 under 8", d, 16'h0061);
    send_m(8'h48);
    rd(3'd3, d); chk("R5 R6 count 8", d, 16'h0062);
    wr(3'd3, 16'hFFFF);
    rd(3'd3, d); chk("R8 ones keep", d, 16'h0062);
    drain("R3 order 8", 8);
    wr(3'd3, 16'hFFFD);
    rd(3'd3, d); chk("R8 clear after drain", d, 16'h0060);

    // R4 overrun
    wr(3'd4, 16'h0000);
    for (int i = 0; i < 17; i++) send_m(8'(8'h80 + i));
    rd(3'd5, d); chk("R4 count full", d, 16'h0010);
    rd(3'd6, d); chk("R4 overrun set", d, 16'h0001);
    rd(3'd6, d); chk("R4 overrun cleared by read", d, 16'h0000);
    drain("R4 kept bytes", 16);
    wr(3'd3, 16'hFFFD);

    // R10 flow control, code 2 -> 4
    wr(3'd4, 16'h0208); repeat (2) @(negedge clk);
    chk("R10 rts empty", rts_n, 0);
    send_m(8'h01); send_m(8'h02); send_m(8'h03);
    chk("R10 rts at 3", rts_n, 0);
    send_m(8'h04);
    chk("R10 rts at 4", rts_n, 1);
    wr(3'd4, 16'h0200); repeat (2) @(negedge clk);
    chk("R10 rts disabled", rts_n, 0);
    wr(3'd4, 16'h0202); wr(3'd4, 16'h0200); rx_model.delete();
    rd(3'd5, d); chk("R11 rx reset", d, 16'h0000);
    wr(3'd3, 16'hFFFC);

    // R7, R9, R11 with transmit disabled
    quiet = 1;
    wr(3'd0, 16'h0010);
    for (int i = 0; i < 10; i++) wr(3'd1, 16'h00EE);
    rd(3'd5, d); chk("R3 R2 tx count held", d, 16'h0A00);
    rd(3'd3, d); chk("R9 tend cleared by write", d & 16'h0040, 16'h0000);
    wr(3'd3, 16'hFFDF);
    rd(3'd3, d); chk("R7 tdfe cleared above trig", d & 16'h0020, 16'h0000);
    wr(3'd0, 16'h0010);
    rd(3'd3, d); chk("R9 tend on disable", d & 16'h0040, 16'h0040);
    wr(3'd4, 16'h0004); wr(3'd4, 16'h0000);
    rd(3'd5, d); chk("R11 tx reset", d, 16'h0000);
    rd(3'd3, d); chk("R7 tdfe after reset", d & 16'h0020, 16'h0020);

    // R12 loopback
    wr(3'd4, 16'h0001); wr(3'd0, 16'h0030);
    wr(3'd1, 16'h005A); wr(3'd1, 16'h00C3);
    rx_model.push_back(8'h5A); rx_model.push_back(8'hC3);
    repeat (2*10*CPB + 60) @(negedge clk);
    rd(3'd5, d); chk("R12 loop count", d, 16'h0002);
    drain("R12 loop data", 2);
    wr(3'd4, 16'h0000); quiet = 0;
    chk("R12 nothing on pin", tx_got.size(), 3);
    wr(3'd3, 16'hFF00);

    // R13 framing error
    send(8'h77, 1'b0); rx_model.push_back(8'h77);
    repeat (CPB) @(negedge clk);
    rd(3'd3, d); chk("R13 fer and er", d & 16'h0088, 16'h0088);
    drain("R13 byte kept", 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule